// File: doc/BRIEF.md
# ATM Adaptation Layer Framing and CRC Engine

This block sits in the cell-payload datapath of a segmentation and reassembly engine. It works on 48-byte cell payloads presented one byte per clock with a start-of-cell marker. Per cell it applies one of three adaptation modes. In raw mode the payload passes untouched. In the segment mode each cell carries its own 2-byte header and 2-byte trailer protected by a CRC-10. In the frame mode a multi-cell frame ends in an 8-byte trailer protected by a CRC-32 that spans the whole frame.

A direction input picks between building and checking. When building, the block overwrites the header and trailer slots of the incoming cell with values from side inputs and with the computed CRC. When checking, it passes every byte through and recomputes the CRC. It raises an error flag on the closing byte of a cell or frame whose CRC does not match. In both directions a per-byte field flag marks the header and trailer bytes, so a downstream stage can drop them and keep only the payload. Cell slots are fixed in position, so the block never stalls its input. Every byte comes out exactly one clock after it went in.

Top module: `aal_framer`

## Requirements
- R1: Each input byte taken with inValid high appears on outData exactly one clock later with outValid high. outSoc marks the output of byte 0 of a cell and outEoc marks the output of byte 47. Out of reset outValid and crcErr are low.
- R2: With modeIn code 0 or 3 (raw), every byte passes unchanged, outField stays low and crcErr stays low, in either direction.
- R3: With modeIn code 1 (segment mode) and rxDir low (build), output byte 0 is {txSegType[1:0], txSeqNum[3:0], txMid[9:8]} and output byte 1 is txMid[7:0]. Both are flagged by outField.
- R4: In segment build mode, output byte 46 is {txLenInd[5:0], c[9:8]} and byte 47 is c[7:0]. Here c is the remainder of M(x)·x^10 divided by x^10+x^9+x^5+x^4+x+1. M is the 384 bits of the output cell, taken most significant bit of byte 0 first, with its last 10 bits zero. Both bytes are flagged by outField.
- R5: With modeIn code 1 and rxDir high (check), bytes pass unchanged and bytes 0, 1, 46 and 47 are flagged. crcErr is high with byte 47 exactly when the received 10-bit CRC field differs from the value defined in R4 for the received cell.
- R6: With modeIn code 2 (frame mode) in build direction, bytes 40 to 43 of a cell marked final by lastCellIn are replaced by txUu, txCpi, txLength[15:8] and txLength[7:0]. Bytes 40 to 47 of that cell are flagged. Non-final cells pass unchanged with no field flags.
- R7: In frame build mode, bytes 44 to 47 of the final cell hold the complement of a CRC-32, most significant byte first. The CRC-32 uses polynomial 0x04C11DB7 and is shifted most significant bit first. It is preset to all ones at the frame's first byte and covers every output byte of the frame up to byte 43 of the final cell.
- R8: In frame check mode, bytes pass unchanged and bytes 40 to 47 of the final cell are flagged. crcErr is high with byte 47 of the final cell exactly when the CRC-32 register over the whole received frame, preset as in R7, differs from 0xC704DD7B. A frame that is one cell long is preset on its only cell.
- R9: crcErr is only ever high on a cell's last output byte. It is never high on a non-final cell in frame mode.
- R10: modeIn, rxDir and lastCellIn are sampled with byte 0 of each cell. Changes to them later in the cell have no effect on that cell's output.
- R11: In every mode, an output byte whose outField is low equals the input byte of the clock before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inSoc | input | 1 | Input byte is byte 0 of a cell |
| inData | input | 8 | Input payload byte |
| modeIn | input | 2 | 0 raw, 1 segment (CRC-10), 2 frame (CRC-32), 3 raw |
| rxDir | input | 1 | 1 check received cells, 0 build cells for sending |
| lastCellIn | input | 1 | Cell closes a frame (frame mode) |
| txSegType | input | 2 | Segment type for the segment header |
| txSeqNum | input | 4 | Sequence number for the segment header |
| txMid | input | 10 | Multiplexing identifier for the segment header |
| txLenInd | input | 6 | Length indicator for the segment trailer |
| txUu | input | 8 | User-to-user byte of the frame trailer |
| txCpi | input | 8 | Common part indicator of the frame trailer |
| txLength | input | 16 | Frame length field of the frame trailer |
| outValid | output | 1 | Output byte valid |
| outSoc | output | 1 | Output byte is byte 0 of a cell |
| outEoc | output | 1 | Output byte is byte 47 of a cell |
| outData | output | 8 | Output byte |
| outField | output | 1 | Output byte is a header or trailer field |
| crcErr | output | 1 | CRC check failed for the cell or frame ending here |

## Verification
The assertions assume the following about the inputs. inValid and inSoc are low while reset is applied. Every cell is exactly 48 valid bytes starting with inSoc. The side inputs hold steady across a cell being built. The stimulus drives whole cells from one task on the falling clock edge and keeps the inputs low between runs. It varies mode and direction only at cell boundaries, except in the one cell that deliberately flips them mid-cell to exercise R10. Checked cells are fed either the engine's own built output or that output with one bit flipped, so each check cell has a known good or bad CRC.

// File: rtl/aal_pkg.sv
package aal_pkg;

  typedef enum logic [1:0] {
    MODE_RAW   = 2'd0,
    MODE_SEG   = 2'd1,
    MODE_FRAME = 2'd2,
    MODE_SPARE = 2'd3
  } aalMode_e;

  // Which value replaces the incoming byte on the way out
  typedef enum logic [3:0] {
    SUB_PASS, SUB_HDR0, SUB_HDR1, SUB_LITAIL, SUB_C10LO,
    SUB_UU, SUB_CPI, SUB_LENHI, SUB_LENLO, SUB_C32
  } subSel_e;

  // What the CRC register does with this byte
  typedef enum logic [2:0] {
    OP_IDLE, OP_UPD10, OP_TAIL10, OP_FIN10, OP_UPD32, OP_SHIFT32
  } crcOp_e;

  typedef struct packed {
    logic    valid;
    logic    soc;
    logic    eoc;
    logic    field;
    logic    rx;
    logic    initZero;
    logic    initOnes;
    logic    check32;
    crcOp_e  op;
    subSel_e sub;
  } ctrlStrobe_t;

  localparam logic [9:0]  CRC10_POLY    = 10'h233;
  localparam logic [31:0] CRC32_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC32_RESIDUE = 32'hC704DD7B;

  function automatic logic [9:0] crc10Byte(input logic [9:0] c, input logic [7:0] d);
    logic [9:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[9] ^ d[i]) r = {r[8:0], 1'b0} ^ CRC10_POLY;
      else             r = {r[8:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [31:0] crc32Byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC32_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/aal_ctrl.sv
module aal_ctrl
  import aal_pkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSoc,
  input  logic [1:0]  modeIn,
  input  logic        rxDir,
  input  logic        lastCellIn,
  output ctrlStrobe_t strobe
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] LI_IDX   = IDX_W'(CELL_BYTES - 2);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(2);
  localparam logic [IDX_W-1:0] UU_IDX   = IDX_W'(CELL_BYTES - 8);
  localparam logic [IDX_W-1:0] CPI_IDX  = IDX_W'(CELL_BYTES - 7);
  localparam logic [IDX_W-1:0] LHI_IDX  = IDX_W'(CELL_BYTES - 6);
  localparam logic [IDX_W-1:0] LLO_IDX  = IDX_W'(CELL_BYTES - 5);
  localparam logic [IDX_W-1:0] C32_IDX  = IDX_W'(CELL_BYTES - 4);

  logic [IDX_W-1:0] posQ, idx;
  aalMode_e modeQ, curMode;
  logic lastQ, curLast, rxQ, curRx, needPresetQ;

  // Per-cell selections are taken with byte 0 and held for the rest of the cell
  always_comb begin
    idx     = inSoc ? '0 : posQ;
    curMode = inSoc ? aalMode_e'(modeIn) : modeQ;
    curLast = inSoc ? lastCellIn : lastQ;
    curRx   = inSoc ? rxDir : rxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ        <= '0;
      modeQ       <= MODE_RAW;
      lastQ       <= 1'b0;
      rxQ         <= 1'b0;
      needPresetQ <= 1'b1;
    end else if (inValid) begin
      posQ  <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
      modeQ <= curMode;
      lastQ <= curLast;
      rxQ   <= curRx;
      if (curMode == MODE_FRAME) needPresetQ <= curLast && (idx == LAST_IDX);
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.op    = OP_IDLE;
    strobe.sub   = SUB_PASS;
    strobe.valid = inValid;
    strobe.soc   = inValid && (idx == '0);
    strobe.eoc   = inValid && (idx == LAST_IDX);
    strobe.rx    = curRx;
    if (inValid) begin
      case (curMode)
        MODE_SEG: begin
          strobe.initZero = (idx == '0);
          if (idx == LI_IDX) begin
            strobe.op    = OP_TAIL10;
            strobe.field = 1'b1;
            if (!curRx) strobe.sub = SUB_LITAIL;
          end else if (idx == LAST_IDX) begin
            strobe.op    = OP_FIN10;
            strobe.field = 1'b1;
            if (!curRx) strobe.sub = SUB_C10LO;
          end else begin
            strobe.op = OP_UPD10;
            if (idx < HDR_END) begin
              strobe.field = 1'b1;
              if (!curRx) strobe.sub = (idx == '0) ? SUB_HDR0 : SUB_HDR1;
            end
          end
        end
        MODE_FRAME: begin
          strobe.initOnes = needPresetQ && (idx == '0);
          strobe.op       = OP_UPD32;
          if (curLast && idx >= UU_IDX) begin
            strobe.field = 1'b1;
            if (idx >= C32_IDX) begin
              if (curRx) strobe.check32 = (idx == LAST_IDX);
              else begin
                strobe.op  = OP_SHIFT32;
                strobe.sub = SUB_C32;
              end
            end else if (!curRx) begin
              if (idx == UU_IDX)       strobe.sub = SUB_UU;
              else if (idx == CPI_IDX) strobe.sub = SUB_CPI;
              else if (idx == LHI_IDX) strobe.sub = SUB_LENHI;
              else if (idx == LLO_IDX) strobe.sub = SUB_LENLO;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/aal_datapath.sv
module aal_datapath
  import aal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  inData,
  input  logic [1:0]  txSegType,
  input  logic [3:0]  txSeqNum,
  input  logic [9:0]  txMid,
  input  logic [5:0]  txLenInd,
  input  logic [7:0]  txUu,
  input  logic [7:0]  txCpi,
  input  logic [15:0] txLength,
  output logic        outValid,
  output logic        outSoc,
  output logic        outEoc,
  output logic [7:0]  outData,
  output logic        outField,
  output logic        crcErr
);
  logic [31:0] crcQ, crcBase, crcD;
  logic [9:0]  c10Base, c10Tail;
  logic [5:0]  liBits;
  logic [1:0]  hiQ;
  logic [7:0]  byteOut;
  logic        errD;

  always_comb begin
    crcBase = strobe.initOnes ? '1 : (strobe.initZero ? '0 : crcQ);
    c10Base = crcBase[9:0];
    liBits  = strobe.rx ? inData[7:2] : txLenInd;
    // Look ahead over the length byte and the zeroed CRC byte in one step
    c10Tail = crc10Byte(crc10Byte(c10Base, {liBits, 2'b00}), 8'h00);

    case (strobe.sub)
      SUB_HDR0:   byteOut = {txSegType, txSeqNum, txMid[9:8]};
      SUB_HDR1:   byteOut = txMid[7:0];
      SUB_LITAIL: byteOut = {txLenInd, c10Tail[9:8]};
      SUB_C10LO:  byteOut = crcBase[7:0];
      SUB_UU:     byteOut = txUu;
      SUB_CPI:    byteOut = txCpi;
      SUB_LENHI:  byteOut = txLength[15:8];
      SUB_LENLO:  byteOut = txLength[7:0];
      SUB_C32:    byteOut = ~crcBase[31:24];
      default:    byteOut = inData;
    endcase

    crcD = crcQ;
    errD = 1'b0;
    case (strobe.op)
      OP_UPD10:   crcD = {22'd0, crc10Byte(c10Base, byteOut)};
      OP_TAIL10:  crcD = {22'd0, c10Tail};
      OP_FIN10: begin
        crcD = crcBase;
        errD = strobe.rx && ({hiQ, inData} != c10Base);
      end
      OP_UPD32: begin
        crcD = crc32Byte(crcBase, byteOut);
        errD = strobe.check32 && (crcD != CRC32_RESIDUE);
      end
      OP_SHIFT32: crcD = {crcBase[23:0], 8'h00};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSoc   <= 1'b0;
      outEoc   <= 1'b0;
      outData  <= '0;
      outField <= 1'b0;
      crcErr   <= 1'b0;
      crcQ     <= '0;
      hiQ      <= '0;
    end else begin
      outValid <= strobe.valid;
      outSoc   <= strobe.soc;
      outEoc   <= strobe.eoc;
      outField <= strobe.field;
      crcErr   <= strobe.valid && errD;
      if (strobe.valid) begin
        outData <= byteOut;
        crcQ    <= crcD;
        if (strobe.op == OP_TAIL10) hiQ <= inData[1:0];
      end
    end
  end

endmodule

// File: rtl/aal_framer.sv
module aal_framer
  import aal_pkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSoc,
  input  logic [7:0]  inData,
  input  logic [1:0]  modeIn,
  input  logic        rxDir,
  input  logic        lastCellIn,
  input  logic [1:0]  txSegType,
  input  logic [3:0]  txSeqNum,
  input  logic [9:0]  txMid,
  input  logic [5:0]  txLenInd,
  input  logic [7:0]  txUu,
  input  logic [7:0]  txCpi,
  input  logic [15:0] txLength,
  output logic        outValid,
  output logic        outSoc,
  output logic        outEoc,
  output logic [7:0]  outData,
  output logic        outField,
  output logic        crcErr
);
  ctrlStrobe_t strobe;

  aal_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSoc      (inSoc),
    .modeIn     (modeIn),
    .rxDir      (rxDir),
    .lastCellIn (lastCellIn),
    .strobe     (strobe)
  );

  aal_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .txSegType (txSegType),
    .txSeqNum  (txSeqNum),
    .txMid     (txMid),
    .txLenInd  (txLenInd),
    .txUu      (txUu),
    .txCpi     (txCpi),
    .txLength  (txLength),
    .outValid  (outValid),
    .outSoc    (outSoc),
    .outEoc    (outEoc),
    .outData   (outData),
    .outField  (outField),
    .crcErr    (crcErr)
  );

endmodule

// File: rtl/aal_framer_chk.sv
module aal_framer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inSoc,
  input logic [7:0]  inData,
  input logic [1:0]  modeIn,
  input logic        rxDir,
  input logic        lastCellIn,
  input logic [1:0]  txSegType,
  input logic [3:0]  txSeqNum,
  input logic [9:0]  txMid,
  input logic [5:0]  txLenInd,
  input logic [7:0]  txUu,
  input logic [7:0]  txCpi,
  input logic [15:0] txLength,
  input logic        outValid,
  input logic        outSoc,
  input logic        outEoc,
  input logic [7:0]  outData,
  input logic        outField,
  input logic        crcErr
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  p_soc_has_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outSoc || outEoc) |-> outValid);

  p_raw_no_field_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(inSoc) && ($past(modeIn) == 2'd0)) |-> !outField);

  p_payload_intact_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outField) |-> (outData == $past(inData)));

  p_err_on_eoc_r9: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> (outEoc && outValid));

endmodule

bind aal_framer aal_framer_chk u_chk (.*);

// File: tb/tb_aal_framer.sv
module tb_aal_framer;
  localparam int CB = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSoc = 1'b0;
  logic [7:0] inData = '0;
  logic [1:0] modeIn = '0;
  logic rxDir = 1'b0, lastCellIn = 1'b0;
  logic [1:0] txSegType = '0;
  logic [3:0] txSeqNum = '0;
  logic [9:0] txMid = '0;
  logic [5:0] txLenInd = '0;
  logic [7:0] txUu = '0, txCpi = '0;
  logic [15:0] txLength = '0;
  logic outValid, outSoc, outEoc, outField, crcErr;
  logic [7:0] outData;

  always #2 clk = ~clk;

  aal_framer #(.CELL_BYTES(CB)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .inData(inData),
    .modeIn(modeIn), .rxDir(rxDir), .lastCellIn(lastCellIn),
    .txSegType(txSegType), .txSeqNum(txSeqNum), .txMid(txMid), .txLenInd(txLenInd),
    .txUu(txUu), .txCpi(txCpi), .txLength(txLength),
    .outValid(outValid), .outSoc(outSoc), .outEoc(outEoc), .outData(outData),
    .outField(outField), .crcErr(crcErr)
  );

  int checks = 0, errors = 0;
  logic [7:0] src [0:191];
  logic [7:0] expD [0:191];
  logic expF [0:191];
  logic expE [0:191];
  logic [7:0] obuf [0:511];
  logic ofld [0:511], oerr [0:511], osoc [0:511], oeoc [0:511];
  int wr = 0;

  always @(negedge clk) begin
    if (outValid) begin
      obuf[wr & 511] = outData;
      ofld[wr & 511] = outField;
      oerr[wr & 511] = crcErr;
      osoc[wr & 511] = outSoc;
      oeoc[wr & 511] = outEoc;
      wr = wr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Remainder of M(x)*x^10 by plain long division with 10 appended zeros
  function automatic logic [9:0] refCrc10();
    logic [10:0] rem;
    rem = '0;
    for (int k = 0; k < CB * 8 + 10; k++) begin
      logic b;
      b = (k < CB * 8) ? expD[k / 8][7 - (k % 8)] : 1'b0;
      rem = {rem[9:0], b};
      if (rem[10]) rem = rem ^ 11'h633;
    end
    return rem[9:0];
  endfunction

  function automatic logic [31:0] refCrc32(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      logic top;
      top = r[31];
      r = r << 1;
      if (top != d[b]) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic runCells(input int nCells, input logic [1:0] m, input bit r, input bit scramble);
    for (int c = 0; c < nCells; c++) begin
      for (int i = 0; i < CB; i++) begin
        @(negedge clk);
        inValid = 1'b1;
        inSoc   = (i == 0);
        inData  = src[c * CB + i];
        if (i == 0) begin
          modeIn = m; rxDir = r; lastCellIn = (c == nCells - 1);
        end else if (scramble) begin
          modeIn = 2'd0; rxDir = ~r; lastCellIn = ~lastCellIn;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSoc = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compareRun(input int base, input int n, input string rD,
                            input string rF, input string rE);
    int bd = 0, bf = 0, be = 0, bs = 0;
    int fi = 0, fe = 0;
    check((wr - base) == n, "R1", "output byte count", wr - base, n);
    for (int i = 0; i < n; i++) begin
      int a;
      a = (base + i) & 511;
      if (obuf[a] !== expD[i]) begin if (bd == 0) fi = i; bd++; end
      if (ofld[a] !== expF[i]) bf++;
      if (oerr[a] !== expE[i]) begin if (be == 0) fe = i; be++; end
      if (osoc[a] !== ((i % CB) == 0)) bs++;
      if (oeoc[a] !== ((i % CB) == CB - 1)) bs++;
    end
    check(bd == 0, rD, $sformatf("data byte %0d", fi), obuf[(base + fi) & 511], expD[fi]);
    check(bf == 0, rF, "field flag mismatches", bf, 0);
    check(be == 0, rE, $sformatf("crcErr at byte %0d", fe), oerr[(base + fe) & 511], expE[fe]);
    check(bs == 0, "R1", "cell marker mismatches", bs, 0);
  endtask

  task automatic expectPass(input int n);
    for (int i = 0; i < n; i++) begin
      expD[i] = src[i]; expF[i] = 1'b0; expE[i] = 1'b0;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [9:0] c10;
    logic [31:0] c32;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(crcErr == 1'b0, "R1", "crcErr in reset", crcErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0 && crcErr == 1'b0, "R1", "idle after reset", {outValid, crcErr}, 0);

    // Raw mode: codes 0 and 3, both directions
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < CB; i++) src[i] = (p[0]) ? ((i[0]) ? 8'h55 : 8'hAA) : 8'(i * 37 + p);
      expectPass(CB);
      base = wr;
      runCells(1, (p >= 2) ? 2'd3 : 2'd0, p[0], 1'b0);
      compareRun(base, CB, "R2 R11", "R2", "R2");
    end

    // Segment mode: build, check good, check corrupted
    for (int k = 0; k < 8; k++) begin
      txSegType = 2'(k); txSeqNum = 4'(k * 3); txMid = 10'(k * 97 + 5); txLenInd = 6'(k * 7 + 1);
      for (int i = 0; i < CB; i++) src[i] = 8'(i * (k + 1) + 13);
      for (int i = 0; i < CB; i++) begin
        expD[i] = src[i]; expF[i] = (i < 2) || (i >= CB - 2); expE[i] = 1'b0;
      end
      expD[0] = {txSegType, txSeqNum, txMid[9:8]};
      expD[1] = txMid[7:0];
      expD[CB-2] = {txLenInd, 2'b00};
      expD[CB-1] = 8'h00;
      c10 = refCrc10();
      expD[CB-2][1:0] = c10[9:8];
      expD[CB-1] = c10[7:0];
      base = wr;
      runCells(1, 2'd1, 1'b0, k == 7);
      compareRun(base, CB, (k == 7) ? "R10" : "R3 R4 R11", "R3 R4", "R4");

      for (int i = 0; i < CB; i++) src[i] = expD[i];
      base = wr;
      runCells(1, 2'd1, 1'b1, 1'b0);
      compareRun(base, CB, "R5 R11", "R5", "R5 R9");

      src[(k * 13 + 1) % CB] = src[(k * 13 + 1) % CB] ^ 8'(1 << (k % 8));
      for (int i = 0; i < CB; i++) expD[i] = src[i];
      expE[CB-1] = 1'b1;
      base = wr;
      runCells(1, 2'd1, 1'b1, 1'b0);
      compareRun(base, CB, "R5", "R5", "R5");
    end

    // Frame mode: frames of one to three cells
    for (int nc = 1; nc <= 3; nc++) begin
      int last;
      last = (nc - 1) * CB;
      txUu = 8'(nc * 17); txCpi = 8'(nc); txLength = 16'(nc * CB - 8 - nc);
      for (int j = 0; j < nc * CB; j++) src[j] = 8'(j * 5 + nc);
      for (int j = 0; j < nc * CB; j++) begin
        expD[j] = src[j]; expF[j] = (j >= last + CB - 8); expE[j] = 1'b0;
      end
      expD[last + CB - 8] = txUu;
      expD[last + CB - 7] = txCpi;
      expD[last + CB - 6] = txLength[15:8];
      expD[last + CB - 5] = txLength[7:0];
      c32 = 32'hFFFFFFFF;
      for (int j = 0; j < last + CB - 4; j++) c32 = refCrc32(c32, expD[j]);
      c32 = ~c32;
      expD[last + CB - 4] = c32[31:24];
      expD[last + CB - 3] = c32[23:16];
      expD[last + CB - 2] = c32[15:8];
      expD[last + CB - 1] = c32[7:0];
      base = wr;
      runCells(nc, 2'd2, 1'b0, 1'b0);
      compareRun(base, nc * CB, "R6 R7 R11", "R6", "R7");

      for (int j = 0; j < nc * CB; j++) src[j] = expD[j];
      base = wr;
      runCells(nc, 2'd2, 1'b1, 1'b0);
      compareRun(base, nc * CB, "R8 R11", "R8", "R8 R9");

      src[(nc * 29) % (nc * CB)] = src[(nc * 29) % (nc * CB)] ^ 8'h10;
      for (int j = 0; j < nc * CB; j++) expD[j] = src[j];
      expE[last + CB - 1] = 1'b1;
      base = wr;
      runCells(nc, 2'd2, 1'b1, 1'b0);
      compareRun(base, nc * CB, "R8", "R8", "R8 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule